// File: doc/BRIEF.md
# Wide Two-Operand Adder with Word-Level Prefix Carry Resolution

This block adds two very wide unsigned operands, from a few hundred to thousands of bits, without running one carry chain across the whole width. Both operands are cut into `NW` words of `WW` bits. Each word is added locally into a `WW+1`-bit result. The low `WW` bits are that word's partial sum. The top bit is the word's generate flag. A word is marked as propagating when its partial sum is all ones.

A Kogge-Stone prefix tree over the word generate/propagate pairs finds the carry into every word in about log2(`NW`) operator levels. The final sum of each word is its partial sum plus that carry, and the carry leaving the top word is the carry-out. The block also brings out the redundant carry-save form that comes before carry resolution: the vector of partial sums, plus a sparse carry vector that holds the word generates at the word boundaries. A wider datapath can take that form and use it directly.

All outputs pass through an optional register stage, selected by the parameter `OUT_REG`, which has a synchronous active-high reset.

Top module: `wsum_top`

## Requirements
- R1: For each word k (operand bits k*WW up to k*WW+WW-1), the bits of `psum_out` in that range equal (a_k + b_k) mod 2^WW.
- R2: The generate of word k is the bit at weight 2^WW of a_k + b_k. A word propagates only when its partial sum is all ones, and then its generate is 0. A word whose partial sum is all ones therefore puts no bit into the carry vector.
- R3: `pcarry_out` has width NW*WW+1. It carries the generate of word k at bit (k+1)*WW, and every other bit is zero, including bit 0. As a result, `psum_out` + `pcarry_out` equals A+B.
- R4: The carry into word 0 is zero. The carry into word k+1 equals g_k | (p_k & carry into word k), which is the ripple recurrence over words.
- R5: {`cout_out`, `sum_out`} equals the exact (NW*WW+1)-bit sum A+B for every pair of operands.
- R6: When OUT_REG=1, every output shows the result for the inputs sampled at the previous rising clock edge, and holds its value between edges.
- R7: While `rst` is high at a rising edge, all registered outputs become zero.
- R8: A generate in a low word travels through any run of all-ones words above it. This includes a run that reaches the top, in which case `cout_out` is 1 and the words in the run become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_in | input | NW*WW | First operand |
| b_in | input | NW*WW | Second operand |
| sum_out | output | NW*WW | Resolved sum, low NW*WW bits |
| cout_out | output | 1 | Carry out of the top word |
| psum_out | output | NW*WW | Redundant form: per-word partial sums |
| pcarry_out | output | NW*WW+1 | Redundant form: word generates at word boundaries |

## Verification
The operand patterns are chosen so that each one isolates a different part of the carry logic.

- **Zero operands and random operands.** These check the plain sum and the redundant split, where carries are short and scattered.
- **All ones plus one.** A single generate in word 0 must cross every propagating word and come out as the carry-out. This tells apart a prefix tree that spans all levels from one that stops short.
- **All-ones runs of several lengths and start points.** A generate placed just below a run of all-ones words checks each prefix distance on its own. Runs that stop one word below the top check that the carry lands in the right word.
- **Both operands all ones.** Every word generates and none propagates, which separates generate from propagate.
- **Timing and reset.** Inputs are changed and the outputs are sampled before and after the clock edge to check the register stage. Reset is applied while nonzero operands are present.

// File: rtl/wsum_pkg.sv
package wsum_pkg;

  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;

  // prefix combine: hi is the more significant span
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.gen  = hi.gen | (hi.prop & lo.gen);
    r.prop = hi.prop & lo.prop;
    return r;
  endfunction

endpackage

// File: rtl/wsum_word_slice.sv
module wsum_word_slice #(
  parameter int WW = 17
) (
  input  logic [WW-1:0] a_w,
  input  logic [WW-1:0] b_w,
  output logic [WW-1:0] s_w,
  output logic          g_w,
  output logic          p_w
);
  logic [WW:0] full;

  assign full = {1'b0, a_w} + {1'b0, b_w};
  assign s_w  = full[WW-1:0];
  assign g_w  = full[WW];
  assign p_w  = &full[WW-1:0];
endmodule

// File: rtl/wsum_prefix_net.sv
module wsum_prefix_net
  import wsum_pkg::*;
#(
  parameter int NW = 8
) (
  input  logic [NW-1:0] g_in,
  input  logic [NW-1:0] p_in,
  output logic [NW:0]   cin_vec
);
  localparam int LV = (NW > 1) ? $clog2(NW) : 1;

  gp_t lvl [LV+1][NW];

  for (genvar i = 0; i < NW; i++) begin : g_seed
    assign lvl[0][i] = '{gen: g_in[i], prop: p_in[i]};
  end

  for (genvar l = 0; l < LV; l++) begin : g_level
    localparam int DIST = 1 << l;
    for (genvar i = 0; i < NW; i++) begin : g_node
      if (i >= DIST) begin : g_op
        assign lvl[l+1][i] = gp_merge(lvl[l][i], lvl[l][i-DIST]);
      end else begin : g_pass
        assign lvl[l+1][i] = lvl[l][i];
      end
    end
  end

  assign cin_vec[0] = 1'b0;
  for (genvar i = 0; i < NW; i++) begin : g_out
    assign cin_vec[i+1] = lvl[LV][i].gen;
  end
endmodule

// File: rtl/wsum_word_final.sv
module wsum_word_final #(
  parameter int WW = 17
) (
  input  logic [WW-1:0] s_w,
  input  logic          c_w,
  output logic [WW-1:0] r_w
);
  assign r_w = s_w + WW'(c_w);
endmodule

// File: rtl/wsum_top.sv
module wsum_top #(
  parameter int WW      = 17,
  parameter int NW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NW*WW-1:0]   a_in,
  input  logic [NW*WW-1:0]   b_in,
  output logic [NW*WW-1:0]   sum_out,
  output logic               cout_out,
  output logic [NW*WW-1:0]   psum_out,
  output logic [NW*WW:0]     pcarry_out
);
  localparam int TW = NW * WW;

  logic [TW-1:0] s_vec;
  logic [TW-1:0] r_vec;
  logic [NW-1:0] g_vec;
  logic [NW-1:0] p_vec;
  logic [NW:0]   cin;
  logic [TW:0]   c_sparse;

  for (genvar k = 0; k < NW; k++) begin : g_word
    wsum_word_slice #(.WW(WW)) u_slice (
      .a_w (a_in[k*WW +: WW]),
      .b_w (b_in[k*WW +: WW]),
      .s_w (s_vec[k*WW +: WW]),
      .g_w (g_vec[k]),
      .p_w (p_vec[k])
    );
    wsum_word_final #(.WW(WW)) u_final (
      .s_w (s_vec[k*WW +: WW]),
      .c_w (cin[k]),
      .r_w (r_vec[k*WW +: WW])
    );
  end

  wsum_prefix_net #(.NW(NW)) u_prefix (
    .g_in    (g_vec),
    .p_in    (p_vec),
    .cin_vec (cin)
  );

  always_comb begin
    c_sparse = '0;
    for (int k = 0; k < NW; k++) c_sparse[(k+1)*WW] = g_vec[k];
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum_out    <= '0;
        cout_out   <= 1'b0;
        psum_out   <= '0;
        pcarry_out <= '0;
      end else begin
        sum_out    <= r_vec;
        cout_out   <= cin[NW];
        psum_out   <= s_vec;
        pcarry_out <= c_sparse;
      end
    end

    // R6: registered result matches the operands of the previous edge
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ({cout_out, sum_out} == ({1'b0, $past(a_in)} + {1'b0, $past(b_in)})));
    // R7: reset clears outputs
    a_r7_reset_clear: assert property (@(posedge clk)
      rst |=> (sum_out == '0 && !cout_out && psum_out == '0 && pcarry_out == '0));
  end else begin : g_comb
    assign sum_out    = r_vec;
    assign cout_out   = cin[NW];
    assign psum_out   = s_vec;
    assign pcarry_out = c_sparse;
  end

  // R2: a word never both generates and propagates
  a_r2_gp_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones(g_vec & p_vec) == 0);
  // R3: redundant form sums to the true total
  a_r3_redundant_sum: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, s_vec} + c_sparse) == ({1'b0, a_in} + {1'b0, b_in}));
  // R4: prefix tree agrees with the word ripple recurrence
  a_r4_cin0_zero: assert property (@(posedge clk) disable iff (rst) cin[0] == 1'b0);
  for (genvar k = 0; k < NW; k++) begin : g_chk
    a_r4_ripple_match: assert property (@(posedge clk) disable iff (rst)
      cin[k+1] == (g_vec[k] | (p_vec[k] & cin[k])));
  end
  // R5: resolved sum is exact
  a_r5_exact_sum: assert property (@(posedge clk) disable iff (rst)
    {cin[NW], r_vec} == ({1'b0, a_in} + {1'b0, b_in}));
endmodule

// File: tb/sim_wsum_top.sv
module sim_wsum_top;
  localparam int WW = 17;
  localparam int NW = 8;
  localparam int TW = WW * NW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] a = '0;
  logic [TW-1:0] b = '0;
  logic [TW-1:0] sum, psum;
  logic          cout;
  logic [TW:0]   pc;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wsum_top #(.WW(WW), .NW(NW), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b),
    .sum_out(sum), .cout_out(cout), .psum_out(psum), .pcarry_out(pc)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] rnd();
    logic [TW-1:0] v = '0;
    for (int k = 0; k < (TW + 31) / 32; k++) v = (v << 32) | TW'($urandom);
    return v;
  endfunction

  // apply at negedge, sample one edge later, check everything
  task automatic apply_check(input logic [TW-1:0] av, input logic [TW-1:0] bv, input string tag);
    logic [TW:0] exp_full;
    logic [TW-1:0] exp_s;
    logic [TW:0] exp_c;
    logic [WW:0] ws;
    @(negedge clk);
    a = av; b = bv;
    @(negedge clk);
    exp_full = {1'b0, av} + {1'b0, bv};
    exp_s = '0; exp_c = '0;
    for (int k = 0; k < NW; k++) begin
      ws = {1'b0, av[k*WW +: WW]} + {1'b0, bv[k*WW +: WW]};
      exp_s[k*WW +: WW] = ws[WW-1:0];
      exp_c[(k+1)*WW] = ws[WW];
    end
    check({"R5 sum ", tag}, 256'({cout, sum}), 256'(exp_full));
    check({"R1 psum ", tag}, 256'(psum), 256'(exp_s));
    check({"R3 pcarry ", tag}, 256'(pc), 256'(exp_c));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R7 reset sum", 256'({cout, sum}), 256'(0));
    check("R7 reset redundant", 256'({psum, pc}), 256'(0));
  endtask

  task automatic t_zero();
    apply_check('0, '0, "zero");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) apply_check(rnd(), rnd(), "random");
  endtask

  task automatic t_full_chain();
    apply_check({TW{1'b1}}, TW'(1), "ones+1");
    check("R8 full chain cout", 256'(cout), 256'(1));
    check("R8 full chain zero", 256'(sum), 256'(0));
  endtask

  task automatic t_runs();
    logic [TW-1:0] av, bv;
    for (int lo = 0; lo < NW - 1; lo++) begin
      for (int hi = lo + 1; hi <= NW; hi++) begin
        av = '0; bv = '0;
        av[lo*WW +: WW] = {WW{1'b1}};
        bv[lo*WW +: WW] = WW'(1);          // generate in word lo, sum bits zero
        for (int k = lo + 1; k < hi; k++) av[k*WW +: WW] = {WW{1'b1}}; // propagating run
        apply_check(av, bv, "R8 run");
        check("R8 run cout", 256'(cout), 256'(hi == NW));
      end
    end
  endtask

  task automatic t_prop_only();
    // R2: all-ones partial sum with no generate leaves carry vector empty
    apply_check({TW{1'b1}}, '0, "prop only");
    check("R2 no generate bits", 256'(pc), 256'(0));
    check("R4 no carry in", 256'({cout, sum}), 256'({1'b0, {TW{1'b1}}}));
  endtask

  task automatic t_all_gen();
    apply_check({TW{1'b1}}, {TW{1'b1}}, "R2 all generate");
  endtask

  task automatic t_timing();
    logic [TW:0] prev;
    apply_check(rnd(), rnd(), "R6 setup");
    prev = {cout, sum};
    @(negedge clk);
    a = rnd(); b = rnd();
    #2;
    check("R6 holds before edge", 256'({cout, sum}), 256'(prev));
    @(negedge clk);
    check("R6 updates after edge", 256'({cout, sum}), 256'({1'b0, a} + {1'b0, b}));
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    a = {TW{1'b1}}; b = TW'(3); rst = 1'b1;
    @(negedge clk);
    check("R7 mid reset", 256'({cout, sum, pc}), 256'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R7 resume", 256'({cout, sum}), 256'({1'b0, a} + {1'b0, b}));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_zero();
    t_random();
    t_full_chain();
    t_runs();
    t_prop_only();
    t_all_gen();
    t_timing();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule